// File: doc/BRIEF.md
# Packed Reciprocal Square-Root Estimator

This block produces an estimate of 1/sqrt(x) for every IEEE-754 single-precision lane of a 256-bit vector. The estimate has a bounded relative error and is not correctly rounded. There is no rounding-control input, so no setting can change a result. For each positive normal lane, the block splits the exponent into an even part and a parity bit. The even part is halved and negated to form the result exponent. The parity bit and the top mantissa bits select a segment of a computed table, and the value inside that segment is found by linear interpolation. Lanes that hold zeros, denormals, negative values, infinities or NaNs take a separate path that returns bit-exact constants.

A width control selects one of two modes. In narrow mode only the low four lanes are computed. The upper 128 result bits then come from one of two places, chosen by a second control: the caller's previous destination half, or all zeros. In wide mode all eight lanes are computed.

Operands enter through a valid/ready handshake. Each accepted vector leaves the block after a fixed number of register stages. The stages are stalled as a whole while the output holds a result that has not been taken.

Top module: `rsq_vec_top`

## Requirements
- R1: For a positive normal lane, the result is a positive normal float whose relative error against the exact 1/sqrt(x) is at most 1.5 × 2^-12.
- R2: A lane of +0 gives +inf (32'h7F800000), and a lane of -0 gives -inf (32'hFF800000).
- R3: A lane with exponent field 0 and a non-zero mantissa is flushed to a zero of the same sign. It therefore gives an infinity of that sign, and no result lane is ever denormal.
- R4: A negative normal lane, or -inf, gives the indefinite value 32'hFFC00000.
- R5: A NaN lane (exponent field all ones, mantissa non-zero) is returned with mantissa bit 22 set and all other bits unchanged. A quiet NaN therefore passes through unchanged.
- R6: A lane of +inf (32'h7F800000) gives +0 (32'h00000000).
- R7: With `wide_i`=1, each 32-bit slice k of `res_o` (bits 32k+31:32k) is computed from the same slice of `src_i`, for all eight lanes.
- R8: With `wide_i`=0, bits 127:0 are computed. Bits 255:128 equal `old_hi_i` as sampled at acceptance when `clr_hi_i`=0, and are all zero when `clr_hi_i`=1. The upper four source lanes have no effect in this mode.
- R9: A vector accepted in one cycle (`in_valid_i` and `in_ready_o` both high) appears on `out_valid_o` exactly LAT cycles later, provided the output is not stalled. Results leave in the order they were accepted.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `res_o` and `out_valid_o` hold and `in_ready_o` is low.
- R11: During reset, `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | An operand vector is offered |
| in_ready_o | output | 1 | The block takes the offered vector this cycle |
| src_i | input | 256 | Eight packed single-precision operands |
| wide_i | input | 1 | 1: eight lanes; 0: four lanes |
| clr_hi_i | input | 1 | Narrow mode only: 1 zeroes bits 255:128, 0 keeps `old_hi_i` |
| old_hi_i | input | 128 | Previous upper destination half |
| out_valid_o | output | 1 | A result vector is presented |
| out_ready_i | input | 1 | The consumer takes the presented result |
| res_o | output | 256 | Eight packed estimates |

## Verification
Two functions can fall in the same cycle: a result held under back-pressure, and a new operand offered at the input. A held result must freeze both the output word and `in_ready_o`. When the stall ends, the held result must be taken and a new operand accepted on the same edge, and nothing may be lost or repeated. The bench makes this happen by toggling `out_ready_i` at random while vectors are offered back to back with random modes and random bit patterns. It judges the outcome with a scoreboard that receives results strictly in order, and with checks that a held word is stable. A second phase keeps `out_ready_i` high, and in it the exact LAT-cycle latency is checked against the cycle in which each vector was accepted.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
  localparam int unsigned FW   = 32;
  localparam int unsigned EW   = 8;
  localparam int unsigned MW   = 23;
  localparam int unsigned BIAS = 127;
  localparam logic [FW-1:0] INDEF = 32'hFFC0_0000;

  typedef enum logic [2:0] {
    K_NORM,
    K_ZERO,
    K_NEG,
    K_INF,
    K_NAN
  } op_kind_e;
endpackage

// File: rtl/rsq_lut.sv
`timescale 1ns/1ps
// Segment table of 1/sqrt(s), s in [1,4), with linear interpolation.
// Requires 2*FR_W+SEG_W <= 63.
module rsq_lut #(
  parameter int unsigned SEG_W = 7,
  parameter int unsigned FR_W  = 24
) (
  input  logic                            par_i,
  input  logic [SEG_W-1:0]                seg_i,
  input  logic [rsq_pkg::MW-SEG_W-1:0]    frac_i,
  output logic [FR_W:0]                   r_o
);
  localparam int unsigned NSEG = 1 << SEG_W;
  localparam int unsigned TW   = rsq_pkg::MW - SEG_W;
  localparam int unsigned DW   = FR_W - SEG_W + 1;
  localparam int unsigned PW   = DW + TW;

  function automatic logic [63:0] isqrt(input logic [63:0] v);
    logic [63:0] x, res, b;
    x   = v;
    res = '0;
    b   = 64'h4000_0000_0000_0000;
    for (int k = 0; k < 32; k++) begin
      if (x >= res + b) begin
        x   = x - (res + b);
        res = (res >> 1) + b;
      end else begin
        res = res >> 1;
      end
      b = b >> 2;
    end
    return res;
  endfunction

  // node value: 2^FR_W / sqrt(s), s = (NSEG+i)/NSEG (par 0) or twice that (par 1)
  function automatic logic [FR_W:0] node(input int unsigned p, input int unsigned i);
    logic [63:0] num, rt;
    num = (64'd1 << (2*FR_W + SEG_W)) / 64'(NSEG + i);
    if (p != 0) num = num >> 1;
    rt = isqrt(num);
    return (FR_W+1)'(rt);
  endfunction

  logic [FR_W:0] base_t [2*NSEG];
  logic [DW-1:0] dlt_t  [2*NSEG];

  for (genvar g = 0; g < 2*NSEG; g++) begin : g_tab
    localparam logic [FR_W:0] B0 = node(g / NSEG, g % NSEG);
    localparam logic [FR_W:0] B1 = node(g / NSEG, g % NSEG + 1);
    assign base_t[g] = B0;
    assign dlt_t[g]  = DW'(B0 - B1);
  end

  logic [SEG_W:0]  idx;
  logic [FR_W:0]   base;
  logic [DW-1:0]   dlt;
  logic [PW-1:0]   prod;
  logic [DW-1:0]   corr;

  assign idx  = {par_i, seg_i};
  assign base = base_t[idx];
  assign dlt  = dlt_t[idx];
  assign prod = {{TW{1'b0}}, dlt} * {{DW{1'b0}}, frac_i};
  assign corr = DW'(prod >> TW);
  assign r_o  = base - {{(FR_W+1-DW){1'b0}}, corr};
endmodule

// File: rtl/rsq_lane.sv
`timescale 1ns/1ps
module rsq_lane
  import rsq_pkg::*;
#(
  parameter int unsigned SEG_W = 7,
  parameter int unsigned FR_W  = 24
) (
  input  logic [FW-1:0] x_i,
  output logic [FW-1:0] y_o
);
  localparam int unsigned XW = EW + 2;

  logic          sgn;
  logic [EW-1:0] ex;
  logic [MW-1:0] mn;
  assign {sgn, ex, mn} = x_i;

  op_kind_e kind;
  always_comb begin
    if (ex == '1 && mn != '0)  kind = K_NAN;
    else if (ex == '0)         kind = K_ZERO;   // denormals flushed
    else if (sgn)              kind = K_NEG;
    else if (ex == '1)         kind = K_INF;
    else                       kind = K_NORM;
  end

  // unbiased exponent is odd when the biased field is even
  logic par;
  assign par = ~ex[0];

  logic [FR_W:0] r;
  rsq_lut #(.SEG_W(SEG_W), .FR_W(FR_W)) u_lut (
    .par_i  (par),
    .seg_i  (mn[MW-1 -: SEG_W]),
    .frac_i (mn[MW-SEG_W-1:0]),
    .r_o    (r)
  );

  logic signed [XW-1:0] e_ev, e_half, e_res;
  logic                 one;
  logic [MW-1:0]        nrm;

  always_comb begin
    one    = r[FR_W];
    e_ev   = XW'(ex) - XW'(BIAS) - XW'(par);
    e_half = e_ev >>> 1;
    e_res  = XW'(BIAS) - e_half - (one ? XW'(0) : XW'(1));
    nrm    = one ? '0 : MW'(r >> (FR_W - 1 - MW));
  end

  always_comb begin
    unique case (kind)
      K_NAN:   y_o = x_i | (FW'(1) << (MW - 1));
      K_ZERO:  y_o = {sgn, {EW{1'b1}}, {MW{1'b0}}};
      K_NEG:   y_o = INDEF;
      K_INF:   y_o = '0;
      default: y_o = {1'b0, EW'(e_res), nrm};
    endcase
  end
endmodule

// File: rtl/rsq_pipe.sv
`timescale 1ns/1ps
module rsq_pipe #(
  parameter int unsigned W   = 256,
  parameter int unsigned LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  logic [LAT-1:0] v_q;
  logic [W-1:0]   d_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int s = 0; s < LAT; s++) d_q[s] <= '0;
    end else if (en_i) begin
      v_q[0] <= v_i;
      d_q[0] <= d_i;
      for (int s = 1; s < LAT; s++) begin
        v_q[s] <= v_q[s-1];
        d_q[s] <= d_q[s-1];
      end
    end
  end

  assign v_o = v_q[LAT-1];
  assign d_o = d_q[LAT-1];
endmodule

// File: rtl/rsq_vec_top.sv
`timescale 1ns/1ps
module rsq_vec_top
  import rsq_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned LAT   = 2,
  parameter int unsigned SEG_W = 7,
  parameter int unsigned FR_W  = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [LANES*FW-1:0]     src_i,
  input  logic                    wide_i,
  input  logic                    clr_hi_i,
  input  logic [LANES*FW/2-1:0]   old_hi_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [LANES*FW-1:0]     res_o
);
  localparam int unsigned VW  = LANES * FW;
  localparam int unsigned NLO = LANES / 2;

  logic [VW-1:0] lane_y, vec_d;
  logic          adv;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rsq_lane #(.SEG_W(SEG_W), .FR_W(FR_W)) u_lane (
      .x_i (src_i[g*FW +: FW]),
      .y_o (lane_y[g*FW +: FW])
    );
    if (g < NLO) begin : g_lo
      assign vec_d[g*FW +: FW] = lane_y[g*FW +: FW];
    end else begin : g_hi
      assign vec_d[g*FW +: FW] = wide_i   ? lane_y[g*FW +: FW] :
                                 clr_hi_i ? '0 : old_hi_i[(g-NLO)*FW +: FW];
    end
  end

  // whole pipe advances unless a result is held
  assign adv        = ~out_valid_o | out_ready_i;
  assign in_ready_o = adv;

  rsq_pipe #(.W(VW), .LAT(LAT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .v_i    (in_valid_i),
    .d_i    (vec_d),
    .v_o    (out_valid_o),
    .d_o    (res_o)
  );
endmodule

// File: rtl/rsq_vec_chk.sv
`timescale 1ns/1ps
module rsq_vec_chk
  import rsq_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned LAT   = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic [LANES*FW-1:0] res_o
);
  int occ_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= 0;
    else occ_q <= occ_q + int'(in_valid_i && in_ready_o) - int'(out_valid_o && out_ready_i);
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_o));

  // R9
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= int'(LAT));

  // R9
  valid_has_item_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> occ_q != 0);

  for (genvar g = 0; g < LANES/2; g++) begin : g_lo
    logic [EW-1:0] ex;
    logic [MW-1:0] mn;
    assign ex = res_o[g*FW+MW +: EW];
    assign mn = res_o[g*FW +: MW];

    // R5
    quiet_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && ex == '1 && mn != '0 |-> mn[MW-1]);

    // R3
    no_denorm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && ex == '0 |-> mn == '0);
  end
endmodule

bind rsq_vec_top rsq_vec_chk #(.LANES(LANES), .LAT(LAT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .res_o       (res_o)
);

// File: tb/sim_rsq_vec_top.sv
`timescale 1ns/1ps
module sim_rsq_vec_top;
  localparam int LANES = 8;
  localparam int LAT   = 2;
  localparam int VW    = 256;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           in_valid_i = 1'b0;
  logic           in_ready_o;
  logic [VW-1:0]  src_i = '0;
  logic           wide_i = 1'b1;
  logic           clr_hi_i = 1'b0;
  logic [127:0]   old_hi_i = '0;
  logic           out_valid_o;
  logic           out_ready_i = 1'b1;
  logic [VW-1:0]  res_o;

  always #2.5 clk_i = ~clk_i;

  rsq_vec_top #(.LANES(LANES), .LAT(LAT)) u0 (.*);

  typedef struct packed {
    logic [VW-1:0] src;
    logic          wide;
    logic          clr;
    logic [127:0]  old;
    int            acc;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit strict_lat = 1'b0, stall_on = 1'b0, done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic real f2r(input logic [31:0] x);
    real m;
    m = 1.0 + real'(x[22:0]) / 8388608.0;
    return m * (2.0 ** (real'(int'(x[30:23])) - 127.0));
  endfunction

  // returns 1 with exact expectation, 0 for the approximated class
  function automatic bit exact_of(input logic [31:0] x, output logic [31:0] e, output string req);
    if (x[30:23] == 8'hFF && x[22:0] != 0) begin e = x | 32'h0040_0000; req = "R5"; return 1; end
    if (x[30:23] == 8'h00) begin
      e = {x[31], 8'hFF, 23'd0};
      req = (x[22:0] == 0) ? "R2" : "R3";
      return 1;
    end
    if (x[31]) begin e = 32'hFFC0_0000; req = "R4"; return 1; end
    if (x[30:23] == 8'hFF) begin e = 32'h0; req = "R6"; return 1; end
    e = 32'h0; req = "R1"; return 0;
  endfunction

  task automatic cmp_lane(input logic [31:0] x, input logic [31:0] a, input string tag);
    logic [31:0] e;
    string req;
    real ev, err;
    if (exact_of(x, e, req)) begin
      chk(a === e, {req, tag}, a, e);
    end else begin
      ev = 1.0 / $sqrt(f2r(x));
      if (a[31] == 1'b0 && a[30:23] != 8'h00 && a[30:23] != 8'hFF) begin
        err = f2r(a) / ev - 1.0;
        if (err < 0.0) err = -err;
        n_chk++;
        if (err > 1.5 / 4096.0) begin
          n_bad++;
          $display("FAIL R1%s act=%h exp~%g x=%h relerr=%g", tag, a, ev, x, err);
        end
      end else begin
        chk(1'b0, {"R1", tag}, a, 32'h0);
      end
    end
  endtask

  task automatic cmp_vec(input item_t it, input logic [VW-1:0] act);
    for (int l = 0; l < LANES; l++) begin
      if (l >= LANES/2 && !it.wide)
        chk(act[l*32 +: 32] === (it.clr ? 32'h0 : it.old[(l-LANES/2)*32 +: 32]),
            "R8", act[l*32 +: 32], it.clr ? 32'h0 : it.old[(l-LANES/2)*32 +: 32]);
      else
        cmp_lane(it.src[l*32 +: 32], act[l*32 +: 32], (l >= LANES/2) ? "/R7" : "");
    end
  endtask

  // driver: called at a negedge, returns at a negedge
  task automatic send(input logic [VW-1:0] s, input bit w, input bit c, input logic [127:0] o);
    bit acc;
    item_t it;
    in_valid_i = 1'b1; src_i = s; wide_i = w; clr_hi_i = c; old_hi_i = o;
    acc = 1'b0;
    while (!acc) begin
      #2;
      if (in_ready_o) begin
        acc = 1'b1;
        it.src = s; it.wide = w; it.clr = c; it.old = o; it.acc = cyc;
        q.push_back(it);
      end
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
  endtask

  // back-pressure generator
  initial begin
    forever begin
      @(negedge clk_i);
      out_ready_i <= stall_on ? 1'($urandom % 2) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit held = 1'b0;
    logic [VW-1:0] held_v;
    item_t it;
    forever begin
      @(negedge clk_i);
      #2;
      if (rst_ni && out_valid_o) begin
        if (held) chk(res_o === held_v, "R10", res_o[31:0], held_v[31:0]);
        if (!held && strict_lat && q.size() != 0)
          chk(cyc == q[0].acc + LAT, "R9", 32'(cyc), 32'(q[0].acc + LAT));
        if (!out_ready_i) begin
          chk(in_ready_o === 1'b0, "R10", {31'd0, in_ready_o}, 32'd0);
          held = 1'b1; held_v = res_o;
        end else begin
          held = 1'b0;
          if (q.size() == 0) chk(1'b0, "R9", 32'd1, 32'd0);
          else begin
            it = q.pop_front();
            cmp_vec(it, res_o);
          end
        end
      end else begin
        held = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    finish_run();
  end

  function automatic logic [31:0] rnd_norm();
    return {1'b0, 8'(1 + $urandom % 254), 23'($urandom)};
  endfunction

  initial begin
    logic [VW-1:0] v;
    int guard;
    repeat (3) @(posedge clk_i);
    #1;
    // R11 reset state
    chk(out_valid_o === 1'b0, "R11", {31'd0, out_valid_o}, 32'd0);
    chk(in_ready_o === 1'b1, "R11", {31'd0, in_ready_o}, 32'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    strict_lat = 1'b1;
    @(negedge clk_i);

    // R1 directed normals: 1, 4, 2, 0.25, 3, max, min, just under 2
    send({32'h3FFF_FFFF, 32'h0080_0000, 32'h7F7F_FFFF, 32'h4040_0000,
          32'h3E80_0000, 32'h4000_0000, 32'h4080_0000, 32'h3F80_0000}, 1'b1, 1'b0, '0);
    // R1 segment edges and odd/even exponents
    send({32'h3F80_0001, 32'h407F_FFFF, 32'h3F00_0000, 32'h3F7F_FFFF,
          32'h0100_0000, 32'h7F00_0000, 32'h3FC0_0000, 32'h40C0_0000}, 1'b1, 1'b0, '0);
    // R1 random normals, back to back
    for (int n = 0; n < 30; n++) begin
      for (int l = 0; l < LANES; l++) v[l*32 +: 32] = rnd_norm();
      send(v, 1'b1, 1'b0, '0);
    end
    // R2 R3 R4 R5 R6 specials
    send({32'h7F80_0001, 32'h7F80_0000, 32'hFF80_0000, 32'hBF80_0000,
          32'h807F_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h0000_0000}, 1'b1, 1'b0, '0);
    send({32'h3F80_0000, 32'h8080_0000, 32'hFFC0_0000, 32'hFFA0_0000,
          32'h7FC0_0001, 32'h7FFF_FFFF, 32'h807F_0000, 32'h0040_0000}, 1'b1, 1'b0, '0);
    // R8 narrow, keep upper
    send({32'h3F80_0000, 32'h4080_0000, 32'h0000_0000, 32'h7F80_0000,
          32'h4080_0000, 32'h8000_0000, 32'hBF80_0000, 32'h3E80_0000}, 1'b0, 1'b0,
         128'hDEAD_BEEF_0123_4567_89AB_CDEF_7F80_0001);
    // R8 narrow, clear upper
    send({32'h3F80_0000, 32'h4080_0000, 32'h0000_0000, 32'h7F80_0000,
          32'h4000_0000, 32'h7F80_0001, 32'h0000_0000, 32'h3F80_0000}, 1'b0, 1'b1,
         128'hFFFF_FFFF_1111_2222_3333_4444_5555_6666);

    guard = 0;
    while (q.size() != 0 && guard < 100) begin @(negedge clk_i); guard++; end

    // R10 random back-pressure with mixed modes and raw patterns
    strict_lat = 1'b0;
    stall_on = 1'b1;
    for (int n = 0; n < 60; n++) begin
      for (int l = 0; l < LANES; l++) v[l*32 +: 32] = (n % 2 == 0) ? $urandom : rnd_norm();
      send(v, 1'($urandom % 2), 1'($urandom % 2),
           {$urandom, $urandom, $urandom, $urandom});
    end
    guard = 0;
    while (q.size() != 0 && guard < 1000) begin @(negedge clk_i); guard++; end
    stall_on = 1'b0;
    chk(q.size() == 0, "R9", 32'(q.size()), 32'd0);
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule